// File: doc/BRIEF.md
# Privileged Program Status Register

This block holds the 32-bit status word that a processor core consults on every cycle, plus one saved copy for each of the five exception modes. Software writes the word one 8-bit byte lane at a time, selected by a field mask. A write lands only when the core reports that it runs privileged. An unprivileged write is dropped without any effect.

On an exception request the block copies the live word into the saved copy of the target mode. In the same cycle it switches the mode bits to that target and raises the interrupt masks. The block also decodes the word for the rest of the core: the current mode, the instruction-set state, and whether IRQ and FIQ are masked. It also shows the saved copy that belongs to the current mode.

Top module: `psr_core`

## Requirements
- R1: After reset the word reads 0x000000D3: supervisor mode, bits 7 and 6 set, bits 5 and 24 clear. Every saved copy reads 0.
- R2: A privileged write (wr_en_i=1, priv_i=1) updates byte lane k (bits 8k+7:8k) exactly when field_mask_i[k] is 1. A lane whose mask bit is 0 keeps its old value.
- R3: A write with priv_i=0 is ignored. The word and all saved copies keep their values.
- R4: A privileged write to lane 0 may set bits 4:0 to any legal mode. The legal modes are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. If the written value is not one of these, the mode bits keep their old value and the rest of lane 0 still updates.
- R5: irq_masked_o equals bit 7 and fiq_masked_o equals bit 6 of the word.
- R6: isa_o is 1 (16-bit state) when bit 5 is 1. It is 2 (bytecode state) when bit 24 is 1 and bit 5 is 0. It is 0 (32-bit state) when both bits are 0.
- R7: An exception request whose target is FIQ, IRQ, supervisor, abort or undefined does the following. It saves the old word into that mode's copy, sets bits 4:0 to the target and sets bit 7. An FIQ target also sets bit 6. All other bits are unchanged.
- R8: An exception request whose target is user, system or an illegal value is ignored.
- R9: When an accepted exception request and a write arrive in the same cycle, the exception is taken and the write is dropped.
- R10: saved_o shows the saved copy of the current mode, and reads 0 in user and system mode. Entry to one mode leaves the other saved copies unchanged.
- R11: mode_o equals bits 4:0 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request for the status word |
| wr_data_i | input | 32 | Write data |
| field_mask_i | input | 4 | Per-byte-lane write enable |
| priv_i | input | 1 | Current code runs privileged |
| exc_en_i | input | 1 | Exception-entry request |
| exc_mode_i | input | 5 | Target mode of the exception |
| word_o | output | 32 | Current status word |
| saved_o | output | 32 | Saved copy for the current mode |
| mode_o | output | 5 | Current mode |
| isa_o | output | 2 | Decoded instruction-set state |
| irq_masked_o | output | 1 | IRQ masked |
| fiq_masked_o | output | 1 | FIQ masked |

## Verification
The bench tries all sixteen field masks, because a lane decoder with swapped bits would corrupt neighbouring flag or control bytes. It writes all 32 mode values, because a design without the legality filter would leave the core in an undefined mode. It also sends an exception request for all 32 target values, because a design that banks user or system requests would corrupt a saved copy. The bench then revisits each exception mode to check that every saved copy has persisted and was not overwritten by a later entry. It also collides a write with an exception entry, because a design that let the write win would lose the exception's mask setting.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = WORD_W / LANE_W;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned NUM_BANKS = 5;
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS);

  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_T = 5;
  localparam int unsigned BIT_J = 24;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  typedef enum logic [1:0] {
    ISA_STD  = 2'd0,
    ISA_CMP  = 2'd1,
    ISA_BYTE = 2'd2
  } isa_e;

  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_00D3;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic mode_banked(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_idx(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_W'(0);
      MODE_IRQ: return BANK_W'(1);
      MODE_SVC: return BANK_W'(2);
      MODE_ABT: return BANK_W'(3);
      default:  return BANK_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/psr_lane_merge.sv
module psr_lane_merge #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned LANE_W    = 8,
  localparam int unsigned NUM_LANES = WORD_W / LANE_W
) (
  input  logic [WORD_W-1:0]    old_i,
  input  logic [WORD_W-1:0]    new_i,
  input  logic [NUM_LANES-1:0] mask_i,
  output logic [WORD_W-1:0]    merged_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign merged_o[k*LANE_W +: LANE_W] = mask_i[k] ? new_i[k*LANE_W +: LANE_W]
                                                    : old_i[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_BANKS = 5,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_en_i,
  input  logic [BANK_W-1:0] save_idx_i,
  input  logic [WORD_W-1:0] save_data_i,
  input  logic              rd_valid_i,
  input  logic [BANK_W-1:0] rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] copy_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  copy_q[b] <= '0;
      else if (save_en_i && save_idx_i == BANK_W'(b)) copy_q[b] <= save_data_i;
    end

    // other copies untouched by an entry to a different mode
    assert_copy_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(save_en_i && save_idx_i == BANK_W'(b)) |=> $stable(copy_q[b]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (rd_valid_i && rd_idx_i == BANK_W'(b)) rd_data_o = copy_q[b];
  end
endmodule

// File: rtl/psr_decode.sv
module psr_decode
  import psr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [1:0]        isa_o,
  output logic              irq_masked_o,
  output logic              fiq_masked_o
);
  isa_e isa;

  always_comb begin
    if (word_i[BIT_T])      isa = ISA_CMP;
    else if (word_i[BIT_J]) isa = ISA_BYTE;
    else                    isa = ISA_STD;
  end

  assign isa_o        = isa;
  assign mode_o       = word_i[MODE_W-1:0];
  assign irq_masked_o = word_i[BIT_I];
  assign fiq_masked_o = word_i[BIT_F];
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic [NUM_LANES-1:0] field_mask_i,
  input  logic                 priv_i,
  input  logic                 exc_en_i,
  input  logic [MODE_W-1:0]    exc_mode_i,
  output logic [WORD_W-1:0]    word_o,
  output logic [WORD_W-1:0]    saved_o,
  output logic [MODE_W-1:0]    mode_o,
  output logic [1:0]           isa_o,
  output logic                 irq_masked_o,
  output logic                 fiq_masked_o
);
  logic [WORD_W-1:0] word_q, word_d, merged, wr_word, exc_word;
  logic              exc_ok, wr_ok;

  assign exc_ok = exc_en_i && mode_banked(exc_mode_i);
  assign wr_ok  = wr_en_i && priv_i && !exc_ok;

  psr_lane_merge #(.WORD_W(WORD_W), .LANE_W(LANE_W)) i_merge (
    .old_i   (word_q),
    .new_i   (wr_data_i),
    .mask_i  (field_mask_i),
    .merged_o(merged)
  );

  // illegal mode values leave the mode bits alone
  always_comb begin
    wr_word = merged;
    if (field_mask_i[0] && !mode_legal(wr_data_i[MODE_W-1:0]))
      wr_word[MODE_W-1:0] = word_q[MODE_W-1:0];
  end

  always_comb begin
    exc_word                = word_q;
    exc_word[MODE_W-1:0]    = exc_mode_i;
    exc_word[BIT_I]         = 1'b1;
    if (exc_mode_i == MODE_FIQ) exc_word[BIT_F] = 1'b1;
  end

  always_comb begin
    if (exc_ok)     word_d = exc_word;
    else if (wr_ok) word_d = wr_word;
    else            word_d = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= RESET_WORD;
    else         word_q <= word_d;
  end

  psr_bank #(.WORD_W(WORD_W), .NUM_BANKS(NUM_BANKS)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_en_i  (exc_ok),
    .save_idx_i (bank_idx(exc_mode_i)),
    .save_data_i(word_q),
    .rd_valid_i (mode_banked(word_q[MODE_W-1:0])),
    .rd_idx_i   (bank_idx(word_q[MODE_W-1:0])),
    .rd_data_o  (saved_o)
  );

  psr_decode i_decode (
    .word_i      (word_q),
    .mode_o      (mode_o),
    .isa_o       (isa_o),
    .irq_masked_o(irq_masked_o),
    .fiq_masked_o(fiq_masked_o)
  );

  assign word_o = word_q;

  assert_user_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i && !exc_en_i) |=> $stable(word_o));

  assert_mode_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_legal(mode_o));

  assert_exc_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && mode_banked(exc_mode_i)) |=>
      (mode_o == $past(exc_mode_i) && irq_masked_o && saved_o == $past(word_o)));

  assert_fiq_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && exc_mode_i == MODE_FIQ) |=> fiq_masked_o);

  assert_bad_exc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_en_i && !mode_banked(exc_mode_i) && !wr_en_i) |=> $stable(word_o));

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane_chk
    assert_lane_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!exc_en_i && !field_mask_i[k]) |=> $stable(word_o[k*LANE_W +: LANE_W]));
  end
endmodule

// File: tb/test_psr_core.sv
module test_psr_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  fmask = '0;
  logic        priv = 1'b0;
  logic        exc_en = 1'b0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] word, saved;
  logic [4:0]  mode;
  logic [1:0]  isa;
  logic        irq_m, fiq_m;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] m_word;
  logic [31:0] m_saved [5];

  always #4 clk = ~clk;

  psr_core i_psr_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .field_mask_i(fmask), .priv_i(priv), .exc_en_i(exc_en), .exc_mode_i(exc_mode),
    .word_o(word), .saved_o(saved), .mode_o(mode), .isa_o(isa),
    .irq_masked_o(irq_m), .fiq_masked_o(fiq_m)
  );

  function automatic bit legal(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  function automatic int slot(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] e_saved;
    logic [1:0]  e_isa;
    e_saved = (slot(m_word[4:0]) >= 0) ? m_saved[slot(m_word[4:0])] : 32'h0;
    e_isa   = m_word[5] ? 2'd1 : (m_word[24] ? 2'd2 : 2'd0);
    cmp({tag, " word"}, word, m_word);
    cmp("R10 saved_o", saved, e_saved);
    cmp("R11 mode_o", {27'h0, mode}, {27'h0, m_word[4:0]});
    cmp("R6 isa_o", {30'h0, isa}, {30'h0, e_isa});
    cmp("R5 irq/fiq", {30'h0, irq_m, fiq_m}, {30'h0, m_word[7], m_word[6]});
  endtask

  // drive one cycle, update model, sample after the edge
  task automatic step(input logic we, input logic [31:0] d, input logic [3:0] fm,
                      input logic pv, input logic ex, input logic [4:0] em,
                      input string tag);
    logic [31:0] nw;
    @(negedge clk);
    wr_en = we; wr_data = d; fmask = fm; priv = pv; exc_en = ex; exc_mode = em;
    if (ex && slot(em) >= 0) begin
      m_saved[slot(em)] = m_word;
      m_word[4:0] = em;
      m_word[7] = 1'b1;
      if (em == 5'h11) m_word[6] = 1'b1;
    end else if (we && pv) begin
      nw = m_word;
      for (int k = 0; k < 4; k++)
        if (fm[k]) nw[8*k +: 8] = d[8*k +: 8];
      if (fm[0] && !legal(d[4:0])) nw[4:0] = m_word[4:0];
      m_word = nw;
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0; exc_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_word = 32'h0000_00D3;
    for (int b = 0; b < 5; b++) m_saved[b] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    cmp("R1 reset word", word, 32'h0000_00D3);
    cmp("R1 reset saved", saved, 32'h0);
    check_all("R1");

    // R2: every field mask
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d;
      d = (~m_word & 32'hFFFF_FFE0) | (m[0] ? 32'h13 : 32'h1F);
      step(1'b1, d, m[3:0], 1'b1, 1'b0, 5'h0, "R2");
    end

    // R3: unprivileged writes
    for (int m = 1; m < 16; m += 3)
      step(1'b1, ~m_word, m[3:0], 1'b0, 1'b0, 5'h0, "R3");

    // R4: every mode value
    for (int v = 0; v < 32; v++)
      step(1'b1, {24'h0, 1'b1, v[0], 1'b0, v[4:0]}, 4'b0001, 1'b1, 1'b0, 5'h0, "R4");

    // R5/R6: every i,f,T,J combination
    for (int c = 0; c < 16; c++)
      step(1'b1, {7'h0, c[3], 16'h0, c[0], c[1], c[2], 5'h13}, 4'b1001, 1'b1,
           1'b0, 5'h0, "R6");

    // R7/R8: every exception target from system mode with masks clear
    for (int t = 0; t < 32; t++) begin
      step(1'b1, {8'hA0 + 8'(t), 16'h0, 3'b000, 5'h1F}, 4'b1001, 1'b1, 1'b0, 5'h0, "R7");
      step(1'b0, 32'h0, 4'h0, 1'b1, 1'b1, t[4:0], (slot(t[4:0]) >= 0) ? "R7" : "R8");
    end

    // R10: each saved copy persists
    foreach (m_saved[b]) begin
      logic [4:0] mm;
      mm = (b == 0) ? 5'h11 : (b == 1) ? 5'h12 : (b == 2) ? 5'h13 : (b == 3) ? 5'h17 : 5'h1B;
      step(1'b1, {24'h0, 3'b000, mm}, 4'b0001, 1'b1, 1'b0, 5'h0, "R10");
    end
    step(1'b1, {24'h0, 3'b000, 5'h10}, 4'b0001, 1'b1, 1'b0, 5'h0, "R10");

    // R9: write collides with exception entry
    step(1'b1, 32'hFFFF_FF1F, 4'hF, 1'b1, 1'b1, 5'h12, "R9");
    step(1'b1, 32'h5500_0013, 4'hF, 1'b1, 1'b1, 5'h11, "R9");
    // R8: bad target with write: write still applies
    step(1'b1, 32'h0F00_0017, 4'h9, 1'b1, 1'b1, 5'h1F, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule